// File: doc/BRIEF.md
# Masked Event Interrupt Distributor

This block keeps a 32-bit sticky event register for a network controller, gates it with a 32-bit mask register, and drives thirteen separate interrupt lines. Each line carries exactly one masked event bit. The lines follow a fixed, non-sequential assignment, so a downstream interrupt controller sees each event on a line of its own.

Event bits are set by one-cycle pulses from the controller's datapath. Software reads the event register and clears bits by writing ones through a simple register port. The same port loads the mask register. Two other register writes raise events directly. A write to the management-frame offset reports that the management transfer is done. A write to the transmit-control offset with bit 0 set reports that a graceful stop is complete.

Interrupt lines are decoded from registered state. They therefore settle in the cycle after any write or event pulse that changes that state.

Top module: `evt_irq_dist`

## Requirements
- R1: After reset the event register and the mask register both read 0, and all thirteen interrupt lines are low.
- R2: A 1 on bit b of `evt_set_i` sets event bit b, readable at offset 0x004 in the next cycle, for the implemented bits 19 to 31. These are: underrun 19, retry limit 20, late collision 21, bus error 22, management done 23, receive buffer 24, receive frame 25, transmit buffer 26, transmit frame 27, graceful stop 28, babbling transmit 29, babbling receive 30, heartbeat 31. Bits 0 to 18 always read 0.
- R3: A write to offset 0x004 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A write to offset 0x008 replaces all 32 mask bits, and the new value reads back at 0x008 from the next cycle.
- R5: Line n is high exactly when both the event bit and the mask bit of its source are 1. The source of each line, from line 0 to line 12, is event bit 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. The line follows a change in the cycle after that change.
- R6: Any write to offset 0x040 sets event bit 23, whatever the data.
- R7: A write to offset 0x0C4 with data bit 0 set sets event bit 28. With data bit 0 clear, such a write leaves the event register unchanged.
- R8: When a set pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R9: A read at any offset other than 0x004 and 0x008 returns 0. A write to any offset other than 0x004, 0x008, 0x040 and 0x0C4 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| evt_set_i | input | 32 | One-cycle event set pulses, one bit per event |
| irq_o | output | 13 | Interrupt lines |

## Verification
The checker runs on every cycle. It checks that set pulses always stick, even against a clearing write, and that clearing writes drop exactly the bits written as 1 that are not pulsed in the same cycle. It also checks that mask writes load, that the two side-effect writes raise their events, and that unmapped reads return zero. It checks the number of lines that are high against the number of active bits. A count cannot show which line carries which event. The bench's sweeps show that: they fire one event at a time and unmask one bit at a time, and compare the result with the stated line order. The bench also covers the reset values, the ignored low bits, and the write with bit 0 clear at the transmit-control offset.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [9:0] OFS_EVT  = 10'h004;
  localparam logic [9:0] OFS_MASK = 10'h008;
  localparam logic [9:0] OFS_MII  = 10'h040;
  localparam logic [9:0] OFS_TCR  = 10'h0C4;

  localparam int unsigned B_UN   = 19;
  localparam int unsigned B_RL   = 20;
  localparam int unsigned B_LC   = 21;
  localparam int unsigned B_EB   = 22;
  localparam int unsigned B_MII  = 23;
  localparam int unsigned B_RXB  = 24;
  localparam int unsigned B_RXF  = 25;
  localparam int unsigned B_TXB  = 26;
  localparam int unsigned B_TXF  = 27;
  localparam int unsigned B_GRA  = 28;
  localparam int unsigned B_BABT = 29;
  localparam int unsigned B_BABR = 30;
  localparam int unsigned B_HB   = 31;

  localparam logic [DATA_W-1:0] IMPL_MASK = 32'hFFF8_0000;

  // line number -> event bit
  function automatic int unsigned line_src(int unsigned ln);
    case (ln)
      0:       return B_TXF;
      1:       return B_TXB;
      2:       return B_UN;
      3:       return B_RL;
      4:       return B_RXF;
      5:       return B_RXB;
      6:       return B_MII;
      7:       return B_LC;
      8:       return B_HB;
      9:       return B_GRA;
      10:      return B_EB;
      11:      return B_BABT;
      default: return B_BABR;
    endcase
  endfunction
endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] raise_o,
  output logic              mask_we_o
);
  logic hit_evt, hit_mask, hit_mii, hit_tcr;

  always_comb begin
    hit_evt  = wr_i && (addr_i == ADDR_W'(OFS_EVT));
    hit_mask = wr_i && (addr_i == ADDR_W'(OFS_MASK));
    hit_mii  = wr_i && (addr_i == ADDR_W'(OFS_MII));
    hit_tcr  = wr_i && (addr_i == ADDR_W'(OFS_TCR));
    clr_o    = hit_evt ? wdata_i : '0;
    raise_o  = '0;
    raise_o[B_MII] = hit_mii;
    raise_o[B_GRA] = hit_tcr && wdata_i[0];
    mask_we_o = hit_mask;
  end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_d_i,
  output logic [DATA_W-1:0] evt_q_o,
  output logic [DATA_W-1:0] mask_q_o
);
  logic [DATA_W-1:0] evt_d;

  // set after clear: a same-cycle pulse wins
  always_comb evt_d = ((evt_q_o & ~clr_i) | set_i) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q_o  <= '0;
      mask_q_o <= '0;
    end else begin
      evt_q_o <= evt_d;
      if (mask_we_i) mask_q_o <= mask_d_i;
    end
  end
endmodule

// File: rtl/evt_line_map.sv
module evt_line_map
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 13
) (
  input  logic [DATA_W-1:0]  active_i,
  output logic [N_LINES-1:0] irq_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    localparam int unsigned SRC = line_src(g);
    assign irq_o[g] = active_i[SRC];
  end
endmodule

// File: rtl/evt_irq_dist.sv
module evt_irq_dist
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned N_LINES = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [DATA_W-1:0]  evt_set_i,
  output logic [N_LINES-1:0] irq_o
);
  logic [DATA_W-1:0] clr, raise, evt_q, mask_q, active;
  logic              mask_we;

  evt_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .clr_o     (clr),
    .raise_o   (raise),
    .mask_we_o (mask_we)
  );

  evt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_set_i | raise),
    .clr_i     (clr),
    .mask_we_i (mask_we),
    .mask_d_i  (wdata_i),
    .evt_q_o   (evt_q),
    .mask_q_o  (mask_q)
  );

  assign active = evt_q & mask_q;

  evt_line_map #(.N_LINES(N_LINES)) u_map (
    .active_i (active),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_EVT):  rdata_o = evt_q;
      ADDR_W'(OFS_MASK): rdata_o = mask_q;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_dist_chk.sv
module evt_irq_dist_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned N_LINES = 13
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [DATA_W-1:0]  evt_set_i,
  input logic [N_LINES-1:0] irq_o,
  input logic [DATA_W-1:0]  evt_q,
  input logic [DATA_W-1:0]  mask_q
);
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_set_i & IMPL_MASK)) |=> ((evt_q & $past(evt_set_i & IMPL_MASK)) == $past(evt_set_i & IMPL_MASK))); // R8

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_EVT)) |=> ((evt_q & $past(wdata_i & ~evt_set_i)) == '0)); // R3

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_MASK)) |=> (mask_q == $past(wdata_i))); // R4

  AST_MII_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_MII)) |=> evt_q[B_MII]); // R6

  AST_GRA_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_TCR) && wdata_i[0]) |=> evt_q[B_GRA]); // R7

  AST_LINE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) == $countones(evt_q & mask_q & IMPL_MASK)); // R5

  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & ~IMPL_MASK) == '0); // R2

  AST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(OFS_EVT) && addr_i != ADDR_W'(OFS_MASK)) |-> (rdata_o == '0)); // R9
endmodule

bind evt_irq_dist evt_irq_dist_chk #(.ADDR_W(ADDR_W), .N_LINES(N_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .evt_set_i (evt_set_i),
  .irq_o     (irq_o),
  .evt_q     (evt_q),
  .mask_q    (mask_q)
);

// File: tb/evt_irq_dist_bench.sv
module evt_irq_dist_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] evt_set_i = '0;
  logic [12:0] irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  evt_irq_dist u_evt_irq_dist (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_set_i(evt_set_i), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  // line order stated in R5
  function automatic int src_of(int ln);
    int t[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[ln];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with given inputs; returns at the following negedge
  task automatic cyc(logic wr, logic [9:0] a, logic [31:0] d, logic [31:0] s);
    @(negedge clk_i);
    wr_i = wr; addr_i = a; wdata_i = d; evt_set_i = s;
    @(negedge clk_i);
    wr_i = 0; evt_set_i = '0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic clear_all();
    cyc(1, 10'h004, 32'hFFFF_FFFF, '0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk_i);
    rd(10'h004, v); chk("R1 evt", v, 0);
    rd(10'h008, v); chk("R1 mask", v, 0);
    chk("R1 irq", 32'(irq_o), 0);
    rst_ni = 1;

    // R4 mask walk
    for (int b = 0; b < 32; b++) begin
      cyc(1, 10'h008, 32'h1 << b, '0);
      rd(10'h008, v); chk("R4 mask load", v, 32'h1 << b);
    end
    cyc(1, 10'h008, 32'hFFFF_FFFF, '0);

    // R2/R5 one event at a time
    for (int ln = 0; ln < 13; ln++) begin
      cyc(0, 10'h000, '0, 32'h1 << src_of(ln));
      rd(10'h004, v); chk("R2 set", v, 32'h1 << src_of(ln));
      chk("R5 line", 32'(irq_o), 32'h1 << ln);
      cyc(1, 10'h004, 32'h1 << src_of(ln), '0);
      rd(10'h004, v); chk("R3 clear", v, 0);
      chk("R5 line off", 32'(irq_o), 0);
    end

    // R2 low bits ignored
    cyc(0, 10'h000, '0, 32'h0007_FFFF);
    rd(10'h004, v); chk("R2 low bits", v, 0);
    chk("R2 low irq", 32'(irq_o), 0);

    // R5 mask gating, all events set
    cyc(0, 10'h000, '0, 32'hFFFF_FFFF);
    rd(10'h004, v); chk("R2 all", v, 32'hFFF8_0000);
    for (int ln = 0; ln < 13; ln++) begin
      cyc(1, 10'h008, 32'h1 << src_of(ln), '0);
      chk("R5 gate", 32'(irq_o), 32'h1 << ln);
      cyc(1, 10'h008, ~(32'h1 << src_of(ln)), '0);
      chk("R5 gate inv", 32'(irq_o), 32'h1FFF & ~(32'h1 << ln));
    end
    cyc(1, 10'h008, 32'hFFFF_FFFF, '0);

    // R3 partial clear
    cyc(1, 10'h004, 32'hAAAA_AAAA, '0);
    rd(10'h004, v); chk("R3 partial", v, 32'hFFF8_0000 & 32'h5555_5555);
    clear_all();

    // R8 set beats clear
    cyc(1, 10'h004, 32'hFFFF_FFFF, 32'h0200_0000);
    rd(10'h004, v); chk("R8 collide", v, 32'h0200_0000);
    clear_all();

    // R6
    cyc(1, 10'h040, 32'h0, '0);
    rd(10'h004, v); chk("R6 mii", v, 32'h0080_0000);
    chk("R6 irq", 32'(irq_o), 32'h1 << 6);
    clear_all();

    // R7
    cyc(1, 10'h0C4, 32'hFFFF_FFFE, '0);
    rd(10'h004, v); chk("R7 bit0 clear", v, 0);
    cyc(1, 10'h0C4, 32'h1, '0);
    rd(10'h004, v); chk("R7 gra", v, 32'h1000_0000);
    chk("R7 irq", 32'(irq_o), 32'h1 << 9);
    clear_all();

    // R9
    cyc(0, 10'h000, '0, 32'h8000_0000);
    rd(10'h040, v); chk("R9 rd mii", v, 0);
    rd(10'h0C4, v); chk("R9 rd tcr", v, 0);
    rd(10'h3FC, v); chk("R9 rd top", v, 0);
    cyc(1, 10'h100, 32'hFFFF_FFFF, '0);
    cyc(1, 10'h00C, 32'h0, '0);
    rd(10'h004, v); chk("R9 wr evt", v, 32'h8000_0000);
    rd(10'h008, v); chk("R9 wr mask", v, 32'hFFFF_FFFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule